// File: doc/BRIEF.md
# Serial Configuration Frame Loader

This block accepts a configuration bitstream one bit per clock cycle and breaks it into its parts: an optional run of leading one bits, a header that carries the load length, a fixed number of fixed-size data frames, and a short postamble. Each frame opens with a zero start bit and closes with four check bits. The block strips the framing and presents the payload bits in order, one per cycle, with a valid strobe. It announces each accepted frame with a one-cycle strobe that carries the frame's index.

Frame size follows from the `ROWS` parameter and frame count from the `COLS` parameter. When the checking strap is high, the check bits of each frame are compared with a CRC computed over that frame's payload. On a mismatch the load stops. The active-low init status output goes low and stays low until reset. A clean load ends with a sticky done flag. It rises once the postamble has passed and the number of bits received since reset has reached the length carried in the header.

Top module: `cfg_frame_loader`

## Requirements
- R1: After reset, one bits are skipped until the 4-bit pattern 0010 completes. The next 24 bits are the length count, most significant bit first. The 4 bits after those are padding, and their values are ignored.
- R2: A frame is 10*ROWS+26 bits: a zero start bit, then 10*ROWS+21 payload bits, then 4 check bits. A load holds 36*COLS+68 frames.
- R3: Each payload bit appears on `data_o` with `data_vld_o` high, once, in arrival order, in the cycle after it is sampled. `data_vld_o` is low while `frame_valid_o` is high.
- R4: With `crc_en_i` high, the check bits (sent most significant first) must equal bits 3..0 of a CRC-16 with polynomial 0x1021. That CRC is zeroed at the start bit and shifted MSB-first over the payload bits only, with feedback = crc[15] xor incoming bit.
- R5: After the last check bit of an accepted frame, `frame_valid_o` is high for exactly one cycle. In that cycle `frame_idx_o` holds the frame's zero-based position in the load.
- R6: While waiting for a start bit, one bits are skipped. The first zero begins the next frame.
- R7: With `crc_en_i` low, the check bit values have no effect and every frame is accepted.
- R8: A check mismatch drives `init_no` low in the cycle after the last check bit. From then until reset there is no further payload strobe, no frame strobe and no done.
- R9: The 8 bits after the last frame are postamble. `done_o` rises in the cycle after the first bit at which the postamble is complete and the count of bits since reset (leading ones and padding included) has reached the length count. Once set, `done_o` stays high and all strobes stay low until reset.
- R10: During reset `init_no` is 1 and `done_o`, `data_vld_o` and `frame_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one bitstream bit per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial bitstream input |
| crc_en_i | input | 1 | Strap: 1 checks frame CRC, 0 ignores check bits |
| data_o | output | 1 | Payload bit |
| data_vld_o | output | 1 | Payload bit strobe |
| frame_valid_o | output | 1 | One-cycle strobe per accepted frame |
| frame_idx_o | output | $clog2(36*COLS+68) | Index of the accepted frame |
| done_o | output | 1 | Load complete, sticky |
| init_no | output | 1 | Active-low status; low after a frame error |

## Verification
The properties assume that every clock edge after reset release carries a real bitstream bit. They also assume that `crc_en_i` is held steady for a whole load, so that strobe spacing and the order of frame indices follow from the frame geometry alone. The stimulus changes the strap only while reset is held. It drives one bit per cycle from reset release onward, including any ones before the preamble, ones between frames and ones after the postamble. This keeps the bit count since reset equal to the count the bench used to build the length field.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  typedef enum logic [3:0] {
    S_HDR, S_LEN, S_PAD, S_SYNC, S_DATA, S_CHK, S_POST, S_TAIL, S_DONE, S_WAIT
  } ldr_state_e;

  localparam int PRE_BITS  = 4;
  localparam int LEN_W     = 24;
  localparam int PAD_BITS  = 4;
  localparam int CHK_BITS  = 4;
  localparam int POST_BITS = 8;
  localparam logic [PRE_BITS-1:0] PREAMBLE = 4'b0010;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  // start + top + bottom + 1 + per-row bits + check
  function automatic int frame_bits(int rows);
    return 1 + 7 + 13 + 1 + 10 * rows + CHK_BITS;
  endfunction

  // left + right + 1 + per-column frames
  function automatic int frame_count(int cols);
    return 26 + 41 + 1 + 36 * cols;
  endfunction
endpackage

// File: rtl/cfg_ldr_crc16.sv
module cfg_ldr_crc16
  import cfg_ldr_pkg::*;
#(
  parameter int OUT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [OUT_W-1:0] crc_o
);
  logic [15:0] crc_q;
  logic        fb;

  assign fb = crc_q[15] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= {crc_q[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  end

  assign crc_o = crc_q[OUT_W-1:0];
endmodule

// File: rtl/cfg_ldr_hdr.sv
module cfg_ldr_hdr
  import cfg_ldr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_en_i,
  input  logic             len_en_i,
  input  logic             bit_i,
  output logic             pre_hit_o,
  output logic [LEN_W-1:0] len_o
);
  logic [PRE_BITS-2:0] sh_q;
  logic [LEN_W-1:0]    len_q;

  // ones before the header keep the window at all-ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '1;
    else if (pre_en_i) sh_q <= {sh_q[PRE_BITS-3:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       len_q <= '0;
    else if (len_en_i) len_q <= {len_q[LEN_W-2:0], bit_i};
  end

  assign pre_hit_o = pre_en_i && ({sh_q, bit_i} == PREAMBLE);
  assign len_o     = len_q;
endmodule

// File: rtl/cfg_ldr_bitcnt.sv
module cfg_ldr_bitcnt
  import cfg_ldr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             reach_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W:0]   cnt_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (en_i && cnt_q != '1)  cnt_q <= cnt_q + LEN_W'(1);
  end

  // count including the bit sampled this cycle
  assign cnt_next = {1'b0, cnt_q} + (LEN_W+1)'(1);
  assign reach_o  = cnt_next >= {1'b0, len_i};
endmodule

// File: rtl/cfg_frame_loader.sv
module cfg_frame_loader
  import cfg_ldr_pkg::*;
#(
  parameter int ROWS = 2,
  parameter int COLS = 1
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      bit_i,
  input  logic                                      crc_en_i,
  output logic                                      data_o,
  output logic                                      data_vld_o,
  output logic                                      frame_valid_o,
  output logic [$clog2(cfg_ldr_pkg::frame_count(COLS))-1:0] frame_idx_o,
  output logic                                      done_o,
  output logic                                      init_no
);
  localparam int FRAME_BITS = frame_bits(ROWS);
  localparam int FRAMES     = frame_count(COLS);
  localparam int DATA_BITS  = FRAME_BITS - 1 - CHK_BITS;
  localparam int POS_MAX    = (DATA_BITS > LEN_W) ? DATA_BITS : LEN_W;
  localparam int POS_W      = $clog2(POS_MAX);
  localparam int IDX_W      = $clog2(FRAMES);

  ldr_state_e          state_q, state_d;
  logic [POS_W-1:0]    pos_q, pos_d, pos_inc;
  logic [IDX_W-1:0]    idx_q, idx_d, oidx_q, oidx_d;
  logic [CHK_BITS-2:0] chk_q, chk_d;
  logic                data_q, dvld_q, dvld_d, fval_q, fval_d;
  logic                done_q, done_d, init_q, init_d;

  logic                pre_hit, reach;
  logic [LEN_W-1:0]    len;
  logic [CHK_BITS-1:0] crc4;

  cfg_ldr_hdr u_hdr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pre_en_i  (state_q == S_HDR),
    .len_en_i  (state_q == S_LEN),
    .bit_i     (bit_i),
    .pre_hit_o (pre_hit),
    .len_o     (len)
  );

  cfg_ldr_crc16 #(.OUT_W(CHK_BITS)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == S_SYNC && !bit_i),
    .en_i   (state_q == S_DATA),
    .bit_i  (bit_i),
    .crc_o  (crc4)
  );

  cfg_ldr_bitcnt u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (state_q != S_DONE && state_q != S_WAIT),
    .len_i   (len),
    .reach_o (reach)
  );

  assign pos_inc = pos_q + POS_W'(1);

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    idx_d   = idx_q;
    oidx_d  = oidx_q;
    chk_d   = chk_q;
    dvld_d  = 1'b0;
    fval_d  = 1'b0;
    done_d  = done_q;
    init_d  = init_q;
    unique case (state_q)
      S_HDR: if (pre_hit) begin
        state_d = S_LEN;
        pos_d   = '0;
      end
      S_LEN: begin
        pos_d = pos_inc;
        if (pos_q == POS_W'(LEN_W - 1)) begin
          state_d = S_PAD;
          pos_d   = '0;
        end
      end
      S_PAD: begin
        pos_d = pos_inc;
        if (pos_q == POS_W'(PAD_BITS - 1)) begin
          state_d = S_SYNC;
          pos_d   = '0;
        end
      end
      S_SYNC: if (!bit_i) begin
        state_d = S_DATA;
        pos_d   = '0;
      end
      S_DATA: begin
        dvld_d = 1'b1;
        pos_d  = pos_inc;
        if (pos_q == POS_W'(DATA_BITS - 1)) begin
          state_d = S_CHK;
          pos_d   = '0;
        end
      end
      S_CHK: begin
        chk_d = {chk_q[CHK_BITS-3:0], bit_i};
        pos_d = pos_inc;
        if (pos_q == POS_W'(CHK_BITS - 1)) begin
          pos_d = '0;
          if (crc_en_i && ({chk_q, bit_i} != crc4)) begin
            state_d = S_WAIT;
            init_d  = 1'b0;
          end else begin
            fval_d = 1'b1;
            oidx_d = idx_q;
            if (idx_q == IDX_W'(FRAMES - 1)) begin
              state_d = S_POST;
            end else begin
              idx_d   = idx_q + IDX_W'(1);
              state_d = S_SYNC;
            end
          end
        end
      end
      S_POST: begin
        pos_d = pos_inc;
        if (pos_q == POS_W'(POST_BITS - 1)) begin
          pos_d = '0;
          if (reach) begin
            state_d = S_DONE;
            done_d  = 1'b1;
          end else begin
            state_d = S_TAIL;
          end
        end
      end
      S_TAIL: if (reach) begin
        state_d = S_DONE;
        done_d  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HDR;
      pos_q   <= '0;
      idx_q   <= '0;
      oidx_q  <= '0;
      chk_q   <= '0;
      data_q  <= 1'b0;
      dvld_q  <= 1'b0;
      fval_q  <= 1'b0;
      done_q  <= 1'b0;
      init_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      idx_q   <= idx_d;
      oidx_q  <= oidx_d;
      chk_q   <= chk_d;
      data_q  <= bit_i;
      dvld_q  <= dvld_d;
      fval_q  <= fval_d;
      done_q  <= done_d;
      init_q  <= init_d;
    end
  end

  assign data_o        = data_q;
  assign data_vld_o    = dvld_q;
  assign frame_valid_o = fval_q;
  assign frame_idx_o   = oidx_q;
  assign done_o        = done_q;
  assign init_no       = init_q;
endmodule

// File: rtl/cfg_frame_loader_chk.sv
module cfg_frame_loader_chk #(
  parameter int COLS = 1
) (
  input logic                                             clk_i,
  input logic                                             rst_ni,
  input logic                                             data_vld_o,
  input logic                                             frame_valid_o,
  input logic [$clog2(cfg_ldr_pkg::frame_count(COLS))-1:0] frame_idx_o,
  input logic                                             done_o,
  input logic                                             init_no
);
  localparam int IDX_W = $clog2(cfg_ldr_pkg::frame_count(COLS));

  logic [IDX_W:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            seen_q <= '0;
    else if (frame_valid_o) seen_q <= seen_q + (IDX_W+1)'(1);
  end

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);

  a_r5_index_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> ({1'b0, frame_idx_o} == seen_q));

  a_r3_strobe_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> !data_vld_o);

  a_r8_wait_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_no |=> !init_no);

  a_r8_wait_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_no |-> (!data_vld_o && !frame_valid_o && !done_o));

  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r9_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!data_vld_o && !frame_valid_o));
endmodule

bind cfg_frame_loader cfg_frame_loader_chk #(.COLS(COLS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .data_vld_o    (data_vld_o),
  .frame_valid_o (frame_valid_o),
  .frame_idx_o   (frame_idx_o),
  .done_o        (done_o),
  .init_no       (init_no)
);

// File: tb/sim_cfg_frame_loader.sv
`timescale 1ns/1ps
module sim_cfg_frame_loader;
  localparam int ROWS  = 2;
  localparam int COLS  = 1;
  localparam int FB    = 10 * ROWS + 26;
  localparam int DB    = FB - 5;
  localparam int NF    = 36 * COLS + 68;
  localparam int IDX_W = $clog2(NF);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             bit_i = 1'b1;
  logic             crc_en_i = 1'b1;
  logic             data_o, data_vld_o, frame_valid_o, done_o, init_no;
  logic [IDX_W-1:0] frame_idx_o;

  cfg_frame_loader #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk_i, .rst_ni, .bit_i, .crc_en_i, .data_o, .data_vld_o,
    .frame_valid_o, .frame_idx_o, .done_o, .init_no
  );

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit stream_q[$];
  bit exp_d_q[$];
  int exp_i_q[$];
  int err_n, len_total;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(logic [15:0] c, bit b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  // R1 R2 R4 R6 R7: build one load and its expectations
  task automatic build_load(int dummies, bit crc_on, int bad_frame, int tail);
    stream_q.delete(); exp_d_q.delete(); exp_i_q.delete();
    err_n = 0;
    repeat (dummies) stream_q.push_back(1'b1);
    stream_q.push_back(1'b0); stream_q.push_back(1'b0);
    stream_q.push_back(1'b1); stream_q.push_back(1'b0);
    repeat (24) stream_q.push_back(1'b0);
    repeat (4) stream_q.push_back(1'b1);
    for (int f = 0; f < NF; f++) begin
      logic [15:0] c;
      logic [3:0]  k;
      repeat (crc_on ? 0 : f % 3) stream_q.push_back(1'b1);
      stream_q.push_back(1'b0);
      c = '0;
      for (int d = 0; d < DB; d++) begin
        bit b;
        b = bit'($urandom_range(0, 1));
        stream_q.push_back(b);
        c = crc_step(c, b);
        if (err_n == 0) exp_d_q.push_back(b);
      end
      k = c[3:0];
      if (f == bad_frame || (!crc_on && f % 4 == 1)) k ^= 4'b0101;
      for (int j = 3; j >= 0; j--) stream_q.push_back(k[j]);
      if (err_n == 0) begin
        if (crc_on && f == bad_frame) err_n = stream_q.size();
        else exp_i_q.push_back(f);
      end
    end
    repeat (8) stream_q.push_back(bit'($urandom_range(0, 1)));
    repeat (tail) stream_q.push_back(1'b1);
    len_total = stream_q.size();
    for (int j = 0; j < 24; j++) stream_q[dummies + 4 + j] = len_total[23 - j];
  endtask

  task automatic status_chk(int n);
    bit exp_done, exp_init;
    exp_done = (err_n == 0) && (n >= len_total);
    exp_init = !((err_n != 0) && (n >= err_n));
    chk(done_o == exp_done, "R9", "done_o", int'(done_o), int'(exp_done));
    chk(init_no == exp_init, "R8", "init_no", int'(init_no), int'(exp_init));
  endtask

  task automatic do_reset(bit crc_on);
    rst_ni = 1'b0;
    bit_i = 1'b1;
    crc_en_i = crc_on;
    repeat (3) @(negedge clk_i);
    // R10
    chk(init_no == 1'b1, "R10", "init_no", int'(init_no), 1);
    chk(done_o == 1'b0, "R10", "done_o", int'(done_o), 0);
    chk(data_vld_o == 1'b0, "R10", "data_vld_o", int'(data_vld_o), 0);
    chk(frame_valid_o == 1'b0, "R10", "frame_valid_o", int'(frame_valid_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic play();
    int n;
    n = 0;
    foreach (stream_q[i]) begin
      bit_i = stream_q[i];
      @(negedge clk_i);
      n++;
      status_chk(n);
    end
    // zeros after the end look like start bits and must stay unused
    repeat (40) begin
      bit_i = 1'b0;
      @(negedge clk_i);
      n++;
      status_chk(n);
    end
    chk(exp_d_q.size() == 0, "R3", "payload bits missing", exp_d_q.size(), 0);
    chk(exp_i_q.size() == 0, "R5", "frame strobes missing", exp_i_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (data_vld_o) begin
        if (exp_d_q.size() == 0) chk(1'b0, "R3", "unexpected payload", 1, 0);
        else begin
          bit e;
          e = exp_d_q.pop_front();
          chk(data_o == e, "R3", "data_o", int'(data_o), int'(e));
        end
      end
      if (frame_valid_o) begin
        if (exp_i_q.size() == 0) chk(1'b0, "R5", "unexpected frame strobe", 1, 0);
        else begin
          int e;
          e = exp_i_q.pop_front();
          chk(int'(frame_idx_o) == e, "R5", "frame_idx_o", int'(frame_idx_o), e);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL R9 watchdog expired: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 R2 R4 R9: checked load, leading ones, length equals stream size
    build_load(8, 1'b1, -1, 0);
    do_reset(1'b1);
    play();
    // R8: bad check bits in frame 5
    build_load(5, 1'b1, 5, 0);
    do_reset(1'b1);
    play();
    // R6 R7 R9: unchecked, ones between frames, wrong check bits, tail ones
    build_load(3, 1'b0, -1, 17);
    do_reset(1'b0);
    play();
    // R1 R8: no leading ones, error on the last frame
    build_load(0, 1'b1, NF - 1, 0);
    do_reset(1'b1);
    play();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule